// File: doc/BRIEF.md
# Region Permission Checker for Load, Store and Fetch Accesses

This block decides, in the same cycle as the request, whether a memory access from a 32-bit core is permitted. It holds a small set of protection entries. Each entry has an 8-bit configuration (read, write and execute grants, an address-match mode and a lock flag) and an address register. Both are written through a narrow register write port. For each access the caller presents the byte address, the access width (byte, halfword or word), the access kind (load, store or instruction fetch) and the privilege level. The block returns a fault flag and an exception cause code.

The block also returns two commit strobes. The memory write path and the register writeback path use them to drop the side effects of a refused access. Entries are searched in index order, and the lowest-numbered entry that touches the access alone decides the outcome. A low entry can therefore carve a narrower permission out of a broad grant held in a higher entry. Each entry matches in one of two modes: a single aligned 4-byte word, or a naturally aligned power-of-two range that is encoded by the trailing ones of its address register. Both the first and the last byte of a sub-word or word access are tested against every entry.

Top module: `pmp_guard`

## Requirements
- R1: After reset every configuration and address register is zero, so no entry matches. A user access then faults and a machine access (privilege code 3) is allowed.
- R2: When several entries match an access, only the lowest-numbered matching entry decides. A restrictive entry 0 overrides a later entry that grants everything.
- R3: In word mode (match field 2), an entry matches exactly the aligned 4-byte word whose byte address shifted right by 2 equals its address register. The neighbouring words do not match.
- R4: In power-of-two mode (match field 3), an address register with t trailing ones covers 2^(t+3) bytes, based at the register with its low t+1 bits cleared, times 4. An all-ones register covers the whole 32-bit space.
- R5: A refused load raises cause 5, and a refused fetch raises cause 1. A user load needs the read grant (config bit 0), and a user fetch needs the execute grant (config bit 2).
- R6: A refused store raises cause 7. A user store needs the write grant (config bit 1), and the read and write grants act independently of each other.
- R7: Byte and halfword accesses at any offset inside a word-mode entry are checked against that entry. A user access whose first and last bytes do not both fall in the deciding entry faults.
- R8: A faulting access drives store_commit and load_commit low. An allowed store raises store_commit, and an allowed load raises load_commit. With acc_valid low, the fault, the cause and both strobes are all 0.
- R9: A machine access is allowed unless the deciding entry has its lock flag (config bit 7) set. In that case the entry's grants apply exactly as they do for a user access.
- R10: A write with csr_is_addr=0 loads csr_wdata[7:0] into the configuration of entry csr_idx. A write with csr_is_addr=1 loads its address register. An entry whose match field (bits 4:3) is 0 or 1 never matches.
- R11: The fault, cause and commit outputs are combinational in the access inputs. They are valid in the same cycle as the request and reflect register writes from earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_is_addr | input | 1 | 0 selects the configuration byte, 1 selects the address register |
| csr_idx | input | IDX_W (2) | Entry index written |
| csr_wdata | input | ADDR_W (32) | Write data; configuration uses bits 7:0 |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W (32) | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| acc_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| acc_priv | input | 2 | 3 machine, any other value user |
| acc_fault | output | 1 | Access refused |
| acc_cause | output | 4 | 1 fetch, 5 load, 7 store; 0 when no fault |
| store_commit | output | 1 | Store may write memory |
| load_commit | output | 1 | Load may write back its register |

## Verification
One fixed layout is swept with every access width at offsets 0, +2 and +3 of a protected word, and with accesses to the words just before and after it. Entry 0 covers that word, and entry 1 grants everything across the whole space. This sweep separates lowest-index priority from any-match merging, and exact word matching from an off-by-one word. Stores and loads run under write-only, read-only, read-write and locked configurations. These runs show that the read and write grants are independent, that each fault reports the right cause code, and that the lock flag alone changes machine-mode results. A 16-byte power-of-two range is probed at its first and last words and at the words just outside it, which pins down how the size is decoded. A halfword that straddles the protected word, and a disabled entry that holds full grants, expose partial-match and disabled-mode mistakes.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_FETCH2 = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      AM_OFF  = 2'd0,
      AM_RSVD = 2'd1,
      AM_WORD = 2'd2,
      AM_POW2 = 2'd3
   } amode_e;

   // Bit 7 lock, bits 6:5 unused, bits 4:3 match mode, bit 2 X, bit 1 W, bit 0 R
   typedef struct packed {
      logic       lock;
      logic [1:0] spare;
      amode_e     amode;
      logic       x;
      logic       w;
      logic       r;
   } ecfg_t;

   localparam logic [3:0] CAUSE_NONE  = 4'd0;
   localparam logic [3:0] CAUSE_FETCH = 4'd1;
   localparam logic [3:0] CAUSE_LOAD  = 4'd5;
   localparam logic [3:0] CAUSE_STORE = 4'd7;

   localparam logic [1:0] PRIV_MACHINE = 2'd3;

endpackage

// File: rtl/pmp_entry_regs.sv
module pmp_entry_regs
   import pmp_guard_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              is_addr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [ADDR_W-1:0] wdata,
   output ecfg_t             cfg_q  [NUM_ENTRIES],
   output logic [ADDR_W-1:0] addr_q [NUM_ENTRIES]
);

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic hit_idx;
      assign hit_idx = we && (idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[e]  <= '0;
            addr_q[e] <= '0;
         end else if (hit_idx) begin
            if (is_addr) addr_q[e] <= wdata;
            else         cfg_q[e]  <= ecfg_t'(wdata[7:0]);
         end
      end
   end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
   import pmp_guard_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  ecfg_t             cfg,
   input  logic [ADDR_W-1:0] region_reg,
   input  logic [ADDR_W-1:0] first_byte,
   input  logic [ADDR_W-1:0] last_byte,
   output logic              hit_first,
   output logic              hit_last
);

   // Low bits that are ignored in power-of-two mode: the trailing ones plus
   // the zero above them.
   logic [ADDR_W-1:0] care_n;
   assign care_n = region_reg ^ (region_reg + ADDR_W'(1));

   function automatic logic byte_hit(input ecfg_t c, input logic [ADDR_W-1:0] reg_v,
                                     input logic [ADDR_W-1:0] ign,
                                     input logic [ADDR_W-1:0] badr);
      logic [ADDR_W-1:0] wadr;
      wadr = {2'b00, badr[ADDR_W-1:2]};
      case (c.amode)
         AM_WORD: return wadr == reg_v;
         AM_POW2: return (wadr & ~ign) == (reg_v & ~ign);
         default: return 1'b0;
      endcase
   endfunction

   assign hit_first = byte_hit(cfg, region_reg, care_n, first_byte);
   assign hit_last  = byte_hit(cfg, region_reg, care_n, last_byte);

endmodule

// File: rtl/pmp_priority_pick.sv
module pmp_priority_pick
   import pmp_guard_pkg::*;
#(
   parameter int NUM_ENTRIES = 4
) (
   input  logic [NUM_ENTRIES-1:0] hit_first,
   input  logic [NUM_ENTRIES-1:0] hit_last,
   input  ecfg_t                  cfg_q [NUM_ENTRIES],
   output logic                   any_hit,
   output logic                   full_hit,
   output ecfg_t                  win_cfg
);

   always_comb begin
      any_hit  = 1'b0;
      full_hit = 1'b0;
      win_cfg  = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hit_first[i] || hit_last[i]) begin
            any_hit  = 1'b1;
            full_hit = hit_first[i] && hit_last[i];
            win_cfg  = cfg_q[i];
         end
      end
   end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
   import pmp_guard_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic              csr_is_addr,
   input  logic [IDX_W-1:0]  csr_idx,
   input  logic [ADDR_W-1:0] csr_wdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic [1:0]        acc_kind,
   input  logic [1:0]        acc_priv,
   output logic              acc_fault,
   output logic [3:0]        acc_cause,
   output logic              store_commit,
   output logic              load_commit
);

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_entries
      $error("pmp_guard: NUM_ENTRIES must be 1..64");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_width
      $error("pmp_guard: ADDR_W must be 8..64");
   end
   if ((2 ** IDX_W) < NUM_ENTRIES) begin : g_bad_idx
      $error("pmp_guard: IDX_W too narrow for NUM_ENTRIES");
   end

   ecfg_t             cfg_q  [NUM_ENTRIES];
   logic [ADDR_W-1:0] addr_q [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] hit_first, hit_last, lock_vec;
   logic [ADDR_W-1:0] last_byte, span;
   logic              any_hit, full_hit, grant, deny, is_mach;
   ecfg_t             win_cfg;
   acc_kind_e         kind;

   pmp_entry_regs #(
      .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(csr_we), .is_addr(csr_is_addr),
      .idx(csr_idx), .wdata(csr_wdata), .cfg_q(cfg_q), .addr_q(addr_q)
   );

   always_comb begin
      case (acc_size)
         2'd0:    span = ADDR_W'(0);
         2'd1:    span = ADDR_W'(1);
         default: span = ADDR_W'(3);
      endcase
   end
   assign last_byte = acc_addr + span;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
      pmp_region_match #(.ADDR_W(ADDR_W)) u_match (
         .cfg(cfg_q[e]), .region_reg(addr_q[e]),
         .first_byte(acc_addr), .last_byte(last_byte),
         .hit_first(hit_first[e]), .hit_last(hit_last[e])
      );
      assign lock_vec[e] = cfg_q[e].lock;
   end

   pmp_priority_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
      .hit_first(hit_first), .hit_last(hit_last), .cfg_q(cfg_q),
      .any_hit(any_hit), .full_hit(full_hit), .win_cfg(win_cfg)
   );

   assign kind    = acc_kind_e'(acc_kind);
   assign is_mach = (acc_priv == PRIV_MACHINE);

   always_comb begin
      case (kind)
         KIND_LOAD:  grant = win_cfg.r;
         KIND_STORE: grant = win_cfg.w;
         default:    grant = win_cfg.x;
      endcase
      if (!any_hit)                     deny = !is_mach;
      else if (is_mach && !win_cfg.lock) deny = 1'b0;
      else                              deny = !full_hit || !grant;
   end

   always_comb begin
      acc_fault = acc_valid && deny;
      acc_cause = CAUSE_NONE;
      if (acc_fault) begin
         case (kind)
            KIND_LOAD:  acc_cause = CAUSE_LOAD;
            KIND_STORE: acc_cause = CAUSE_STORE;
            default:    acc_cause = CAUSE_FETCH;
         endcase
      end
   end

   assign store_commit = acc_valid && !deny && (kind == KIND_STORE);
   assign load_commit  = acc_valid && !deny && (kind == KIND_LOAD);

endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk #(
   parameter int NUM_ENTRIES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   acc_valid,
   input logic [1:0]             acc_kind,
   input logic [1:0]             acc_priv,
   input logic                   acc_fault,
   input logic [3:0]             acc_cause,
   input logic                   store_commit,
   input logic                   load_commit,
   input logic [NUM_ENTRIES-1:0] lock_vec
);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!acc_fault && acc_cause == 4'd0 && !store_commit && !load_commit));

   assert_fault_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault |-> (!store_commit && !load_commit));

   assert_store_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_kind == 2'd1 && !acc_fault) |-> store_commit);

   assert_load_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fault && acc_kind == 2'd0) |-> acc_cause == 4'd5);

   assert_store_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fault && acc_kind == 2'd1) |-> acc_cause == 4'd7);

   assert_mach_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_priv == 2'd3 && lock_vec == '0) |-> !acc_fault);

endmodule

bind pmp_guard pmp_guard_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
   .acc_priv(acc_priv), .acc_fault(acc_fault), .acc_cause(acc_cause),
   .store_commit(store_commit), .load_commit(load_commit), .lock_vec(lock_vec)
);

// File: tb/pmp_guard_tb.sv
module pmp_guard_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N_VEC = 12;

   typedef struct packed {
      logic [1:0]  priv;
      logic [1:0]  kind;
      logic [1:0]  size;
      logic [31:0] addr;
      logic        fault;
      logic [3:0]  cause;
   } vec_t;

   // Entry 0: word mode on 0x1000 with W,X only; entry 1: whole space RWX
   localparam vec_t TBL [N_VEC] = '{
      '{2'd0, 2'd1, 2'd2, 32'h1000, 1'b0, 4'd0},  // R6 store word allowed
      '{2'd0, 2'd0, 2'd2, 32'h1000, 1'b1, 4'd5},  // R5/R2 load word refused
      '{2'd0, 2'd1, 2'd1, 32'h1002, 1'b0, 4'd0},  // R7 store half +2
      '{2'd0, 2'd0, 2'd1, 32'h1002, 1'b1, 4'd5},  // R7 load half +2
      '{2'd0, 2'd1, 2'd0, 32'h1003, 1'b0, 4'd0},  // R7 store byte +3
      '{2'd0, 2'd0, 2'd0, 32'h1003, 1'b1, 4'd5},  // R7 load byte +3
      '{2'd0, 2'd0, 2'd2, 32'h1004, 1'b0, 4'd0},  // R3 next word
      '{2'd0, 2'd0, 2'd2, 32'h0FFC, 1'b0, 4'd0},  // R3 previous word
      '{2'd0, 2'd2, 2'd2, 32'h1000, 1'b0, 4'd0},  // R5 fetch with X
      '{2'd3, 2'd0, 2'd2, 32'h1000, 1'b0, 4'd0},  // R9 machine unlocked
      '{2'd0, 2'd0, 2'd1, 32'h1003, 1'b1, 4'd5},  // R7 straddling half
      '{2'd0, 2'd1, 2'd1, 32'h1003, 1'b1, 4'd7}   // R7 straddling store
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic        csr_is_addr = 1'b0;
   logic [1:0]  csr_idx = '0;
   logic [31:0] csr_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic [1:0]  acc_kind = '0;
   logic [1:0]  acc_priv = '0;
   logic        acc_fault;
   logic [3:0]  acc_cause;
   logic        store_commit, load_commit;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pmp_guard u_dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_is_addr(csr_is_addr),
      .csr_idx(csr_idx), .csr_wdata(csr_wdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
      .acc_priv(acc_priv), .acc_fault(acc_fault), .acc_cause(acc_cause),
      .store_commit(store_commit), .load_commit(load_commit)
   );

   task automatic wr(input logic is_addr, input logic [1:0] idx, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_is_addr = is_addr; csr_idx = idx; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic probe(input string req, input logic [1:0] priv, input logic [1:0] kind,
                        input logic [1:0] size, input logic [31:0] addr,
                        input logic exp_fault, input logic [3:0] exp_cause);
      logic exp_sc, exp_lc;
      @(negedge clk);
      acc_valid = 1'b1; acc_priv = priv; acc_kind = kind; acc_size = size; acc_addr = addr;
      #1;
      exp_sc = !exp_fault && kind == 2'd1;
      exp_lc = !exp_fault && kind == 2'd0;
      checks++;
      if (acc_fault !== exp_fault || acc_cause !== exp_cause ||
          store_commit !== exp_sc || load_commit !== exp_lc) begin
         failures++;
         $display("FAIL %s addr=%h kind=%0d: fault/cause/sc/lc=%b/%0d/%b/%b expected %b/%0d/%b/%b",
                  req, addr, kind, acc_fault, acc_cause, store_commit, load_commit,
                  exp_fault, exp_cause, exp_sc, exp_lc);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: idle outputs
      #1;
      checks++;
      if (acc_fault !== 1'b0 || acc_cause !== 4'd0 || store_commit !== 1'b0 || load_commit !== 1'b0) begin
         failures++;
         $display("FAIL R8 idle: fault=%b cause=%0d expected 0/0", acc_fault, acc_cause);
      end
      rst_n = 1'b1;

      // R1 reset state
      probe("R1 user after reset", 2'd0, 2'd0, 2'd2, 32'h1000, 1'b1, 4'd5);
      probe("R1 machine after reset", 2'd3, 2'd1, 2'd2, 32'h1000, 1'b0, 4'd0);

      // R10 disabled entry with full grants never matches
      wr(1'b1, 2'd0, 32'h400);
      wr(1'b0, 2'd0, 32'h07);
      probe("R10 off mode", 2'd0, 2'd0, 2'd2, 32'h1000, 1'b1, 4'd5);
      wr(1'b0, 2'd0, 32'h0F);  // match field 1: unsupported, never matches
      probe("R10 mode1", 2'd0, 2'd0, 2'd2, 32'h1000, 1'b1, 4'd5);
      wr(1'b0, 2'd0, 32'h00);

      // R4 power-of-two range: reg 0x801 -> 16 bytes at 0x2000, read only
      wr(1'b1, 2'd2, 32'h801);
      wr(1'b0, 2'd2, 32'h19);
      probe("R4 first word", 2'd0, 2'd0, 2'd2, 32'h2000, 1'b0, 4'd0);
      probe("R4 last word", 2'd0, 2'd0, 2'd2, 32'h200C, 1'b0, 4'd0);
      probe("R4 above", 2'd0, 2'd0, 2'd2, 32'h2010, 1'b1, 4'd5);
      probe("R4 below", 2'd0, 2'd0, 2'd2, 32'h1FFC, 1'b1, 4'd5);
      probe("R6 store in read-only range", 2'd0, 2'd1, 2'd2, 32'h2008, 1'b1, 4'd7);

      // R4 whole space via all ones, R2 priority layout
      wr(1'b1, 2'd1, 32'hFFFF_FFFF);
      wr(1'b0, 2'd1, 32'h1F);
      probe("R4 all ones top", 2'd0, 2'd1, 2'd2, 32'hFFFF_FFFC, 1'b0, 4'd0);
      wr(1'b0, 2'd0, 32'h16);  // word mode, W+X
      for (int i = 0; i < N_VEC; i++) begin
         probe($sformatf("R2/R3/R5/R6/R7 vec%0d", i), TBL[i].priv, TBL[i].kind,
               TBL[i].size, TBL[i].addr, TBL[i].fault, TBL[i].cause);
      end

      // R6 read only: loads ok, stores refused
      wr(1'b0, 2'd0, 32'h15);
      probe("R6 ro store word", 2'd0, 2'd1, 2'd2, 32'h1000, 1'b1, 4'd7);
      probe("R6 ro load word", 2'd0, 2'd0, 2'd2, 32'h1000, 1'b0, 4'd0);
      probe("R6 ro store byte +3", 2'd0, 2'd1, 2'd0, 32'h1003, 1'b1, 4'd7);
      probe("R6 ro load half +2", 2'd0, 2'd0, 2'd1, 32'h1002, 1'b0, 4'd0);

      // R5 fetch without X
      wr(1'b0, 2'd0, 32'h13);
      probe("R5 fetch no X", 2'd0, 2'd2, 2'd2, 32'h1000, 1'b1, 4'd1);
      probe("R9 machine fetch unlocked", 2'd3, 2'd2, 2'd2, 32'h1000, 1'b0, 4'd0);

      // R9 locked entry binds machine mode
      wr(1'b0, 2'd0, 32'h93);
      probe("R9 machine fetch locked", 2'd3, 2'd2, 2'd2, 32'h1000, 1'b1, 4'd1);
      probe("R9 machine load locked", 2'd3, 2'd0, 2'd2, 32'h1000, 1'b0, 4'd0);
      probe("R9 machine elsewhere", 2'd3, 2'd2, 2'd2, 32'h3000, 1'b0, 4'd0);

      // R11 same-cycle response to input change after register update
      wr(1'b0, 2'd0, 32'h91);
      probe("R11 store after cfg write", 2'd0, 2'd1, 2'd2, 32'h1000, 1'b1, 4'd7);

      @(negedge clk);
      acc_valid = 1'b0;
      #1;
      checks++;
      if (acc_fault !== 1'b0 || acc_cause !== 4'd0) begin
         failures++;
         $display("FAIL R8 invalid request: fault=%b cause=%0d expected 0/0", acc_fault, acc_cause);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule